// File: doc/BRIEF.md
# Masked Address Watchpoint Comparator Bank

This block holds a small set of programmable comparators that watch the data-address and program-counter streams of a processor. Each comparator keeps a 32-bit reference value, a mask count that tells it how many low-order bits to ignore, and a function word. The function word selects what a hit produces: a watchpoint event, a trace trigger, a PC-sample trigger or a data-address-sample trigger. For the first two it also selects which stream is compared.

Comparator 0 can compare against a free-running 32-bit cycle counter instead of an address. This lets it fire at a chosen time. Software programs the bank through a simple word-addressed register port. A global trace-enable input switches the whole unit on and off. Each hit produces a one-cycle pulse on the event output that belongs to the comparator's function.

Top module: `addr_watch_bank`

## Requirements
- R1: After reset, every compare, mask and function register and the cycle counter hold 0, and all event outputs are low.
- R2: The register map is byte-addressed on `reg_addr`:
  - the cycle counter is at 0x04;
  - comparator i has its compare register at 0x10+16*i, its mask register at 0x14+16*i and its function register at 0x18+16*i.
  - A read returns the stored value, zero-extended, in the same cycle as `reg_rd`. Any other address reads 0 and ignores writes.
- R3: A mask write stores the written value, or 15 if the value is greater than 15. A stored mask N makes the comparator ignore address bits [N-1:0]. N=0 compares all 32 bits.
- R4: Function bits [2:0] encode the function: 1 watchpoint, 2 trace trigger, 3 PC-sample trigger, 4 data-address-sample trigger. The codes 0 and 5 to 7 leave the comparator off. A hit sampled at one clock edge pulses, for one cycle after that edge, the output for its code only: `ev_watch`, `ev_trig`, `ev_pcs` or `ev_das` respectively.
- R5: Function bit 4 set selects the PC stream (`pc`, `pc_vld`) for codes 1 and 2. For codes 3 and 4 the data-address stream is always compared, whatever bit 4 holds.
- R6: Function bit 5 of comparator 0 selects the cycle counter as the compare operand, with no valid strobe needed. On the other comparators bit 5 is not stored: it reads back 0 and has no effect. Bits 3 and 31:6 are not stored on any comparator.
- R7: A comparator whose code is off never produces an event, whatever its compare and mask contents.
- R8: While `trace_en` is low:
  - no event is produced;
  - the cycle counter holds its value;
  - register writes are ignored;
  - reads return 0.
- R9: While `trace_en` is high, the cycle counter increments by one every clock and wraps from 0xFFFFFFFF to 0. A write to it loads the written value instead of incrementing.
- R10: An address comparison counts only in a cycle where the valid strobe of the compared stream is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Global enable for the whole unit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| daddr | input | 32 | Data address stream |
| daddr_vld | input | 1 | Data address valid |
| pc | input | 32 | Program counter stream |
| pc_vld | input | 1 | Program counter valid |
| ev_watch | output | 4 | Watchpoint event pulse per comparator |
| ev_trig | output | 4 | Trace trigger pulse per comparator |
| ev_pcs | output | 4 | PC-sample trigger pulse per comparator |
| ev_das | output | 4 | Data-address-sample trigger pulse per comparator |

## Verification
The bench goes after the mask edges: a write above 15 must read back as 15, and an address differing only in ignored bits must still hit. A design that treated the mask as a bit pattern, or truncated the written value instead of clamping it, would miss or fire at the wrong addresses. It walks every function code on one comparator, including the unused codes 5 to 7. A decoder that mapped those codes to an output, or routed a hit to the wrong pulse, shows up at once. It also checks that the PC-select bit is ignored for the sample functions, and that the cycle-counter mode fires exactly once over a window. A wrong stream choice would pulse at the wrong time, and a counter that missed an increment or wrapped wrongly would pulse at the wrong time or not at all. Finally, it drives matching addresses with `trace_en` low or the valid strobe low, and writes while disabled. A design that leaked events or accepted those writes would fail the read-back.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int DATA_W  = 32;
  localparam int MASK_W  = 4;
  localparam int FUNC_W  = 6;
  localparam int CODE_W  = 3;
  localparam int PC_BIT  = 4;
  localparam int CYC_BIT = 5;
  localparam int NUM_EV  = 4;

  typedef enum logic [CODE_W-1:0] {
    FN_OFF   = 3'd0,
    FN_WATCH = 3'd1,
    FN_TRIG  = 3'd2,
    FN_PCSMP = 3'd3,
    FN_DASMP = 3'd4
  } fn_code_e;

  // Mask register value after a write: counts above 15 saturate.
  function automatic logic [MASK_W-1:0] clamp_mask(input logic [DATA_W-1:0] w);
    logic [MASK_W-1:0] r;
    if (|w[DATA_W-1:MASK_W]) r = {MASK_W{1'b1}};
    else r = w[MASK_W-1:0];
    return r;
  endfunction

  // Bits of the function word that are stored for a comparator.
  function automatic logic [FUNC_W-1:0] func_keep(input logic allow_cyc);
    logic [FUNC_W-1:0] k;
    k = '0;
    k[CODE_W-1:0] = {CODE_W{1'b1}};
    k[PC_BIT] = 1'b1;
    k[CYC_BIT] = allow_cyc;
    return k;
  endfunction

  function automatic logic code_active(input logic [CODE_W-1:0] c);
    return (c >= FN_WATCH) && (c <= FN_DASMP);
  endfunction

  function automatic logic code_uses_pc(input logic [CODE_W-1:0] c);
    return (c == FN_WATCH) || (c == FN_TRIG);
  endfunction

  // Equality that disregards the lowest n bits.
  function automatic logic masked_eq(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic [MASK_W-1:0] n);
    logic [DATA_W-1:0] keep;
    keep = {DATA_W{1'b1}} << n;
    return ((a ^ b) & keep) == '0;
  endfunction

  // Event lane for a function code: 0 watch, 1 trig, 2 pc sample, 3 da sample.
  function automatic logic [NUM_EV-1:0] code_lane(input logic [CODE_W-1:0] c);
    logic [NUM_EV-1:0] l;
    l = '0;
    case (c)
      FN_WATCH: l[0] = 1'b1;
      FN_TRIG:  l[1] = 1'b1;
      FN_PCSMP: l[2] = 1'b1;
      FN_DASMP: l[3] = 1'b1;
      default:  l = '0;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/wp_cycle_counter.sv
module wp_cycle_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (run) begin
      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/wp_cmp_regs.sv
module wp_cmp_regs
  import wp_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_comp,
  input  logic              wr_mask,
  input  logic              wr_func,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] comp_q,
  output logic [MASK_W-1:0] mask_q,
  output logic [FUNC_W-1:0] func_q
);

  localparam logic [FUNC_W-1:0] KEEP = func_keep(IDX == 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_q <= '0;
      mask_q <= '0;
      func_q <= '0;
    end else begin
      if (wr_comp) comp_q <= wdata;
      if (wr_mask) mask_q <= clamp_mask(wdata);
      if (wr_func) func_q <= wdata[FUNC_W-1:0] & KEEP;
    end
  end

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
  import wp_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic [DATA_W-1:0] comp_q,
  input  logic [MASK_W-1:0] mask_q,
  input  logic [FUNC_W-1:0] func_q,
  input  logic [DATA_W-1:0] daddr,
  input  logic              daddr_vld,
  input  logic [DATA_W-1:0] pc,
  input  logic              pc_vld,
  input  logic [DATA_W-1:0] cyc_count,
  output logic              hit,
  output logic              cyc_mode,
  output logic [NUM_EV-1:0] ev_q
);

  logic [CODE_W-1:0] code;
  logic              pc_mode;
  logic [DATA_W-1:0] operand;
  logic              op_vld;

  assign code = func_q[CODE_W-1:0];

  generate
    if (IDX == 0) begin : g_cyc
      assign cyc_mode = func_q[CYC_BIT];
    end else begin : g_nocyc
      assign cyc_mode = 1'b0;
    end
  endgenerate

  assign pc_mode = func_q[PC_BIT] && code_uses_pc(code);

  always_comb begin
    if (cyc_mode) begin
      operand = cyc_count;
      op_vld  = 1'b1;
    end else if (pc_mode) begin
      operand = pc;
      op_vld  = pc_vld;
    end else begin
      operand = daddr;
      op_vld  = daddr_vld;
    end
  end

  assign hit = trace_en && code_active(code) && op_vld &&
               masked_eq(operand, comp_q, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else ev_q <= hit ? code_lane(code) : '0;
  end

endmodule

// File: rtl/addr_watch_bank.sv
module addr_watch_bank
  import wp_pkg::*;
#(
  parameter int NUM_CMP  = 4,
  parameter int REG_AW   = 8,
  parameter int CNT_ADDR = 'h04,
  parameter int CMP_BASE = 'h10,
  parameter int CMP_STEP = 'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trace_en,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [31:0]         daddr,
  input  logic                daddr_vld,
  input  logic [31:0]         pc,
  input  logic                pc_vld,
  output logic [NUM_CMP-1:0]  ev_watch,
  output logic [NUM_CMP-1:0]  ev_trig,
  output logic [NUM_CMP-1:0]  ev_pcs,
  output logic [NUM_CMP-1:0]  ev_das
);

  localparam logic [REG_AW-1:0] CNT_A = REG_AW'(CNT_ADDR);

  logic                               wr_ok;
  logic                               rd_ok;
  logic                               cnt_ld;
  logic [DATA_W-1:0]                  cyc_count;
  logic [NUM_CMP-1:0]                 sel_comp, sel_mask, sel_func;
  logic [NUM_CMP-1:0][DATA_W-1:0]     comp_arr;
  logic [NUM_CMP-1:0][MASK_W-1:0]     mask_arr;
  logic [NUM_CMP-1:0][FUNC_W-1:0]     func_arr;
  logic [NUM_CMP-1:0][CODE_W-1:0]     cfg_code;
  logic [NUM_CMP-1:0]                 hit_vec;
  logic [NUM_CMP-1:0]                 cmode_vec;
  logic [NUM_CMP-1:0][NUM_EV-1:0]     ev_arr;
  logic                               cyc0_mode;

  assign wr_ok  = reg_wr && trace_en;
  assign rd_ok  = reg_rd && trace_en;
  assign cnt_ld = wr_ok && (reg_addr == CNT_A);

  wp_cycle_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (trace_en),
    .load     (cnt_ld),
    .load_val (reg_wdata),
    .count    (cyc_count)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
      localparam logic [REG_AW-1:0] BASE_A = REG_AW'(CMP_BASE + CMP_STEP * gi);

      assign sel_comp[gi] = (reg_addr == BASE_A);
      assign sel_mask[gi] = (reg_addr == BASE_A + REG_AW'(4));
      assign sel_func[gi] = (reg_addr == BASE_A + REG_AW'(8));

      wp_cmp_regs #(.IDX(gi)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_comp (wr_ok && sel_comp[gi]),
        .wr_mask (wr_ok && sel_mask[gi]),
        .wr_func (wr_ok && sel_func[gi]),
        .wdata   (reg_wdata),
        .comp_q  (comp_arr[gi]),
        .mask_q  (mask_arr[gi]),
        .func_q  (func_arr[gi])
      );

      wp_match_unit #(.IDX(gi)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .trace_en  (trace_en),
        .comp_q    (comp_arr[gi]),
        .mask_q    (mask_arr[gi]),
        .func_q    (func_arr[gi]),
        .daddr     (daddr),
        .daddr_vld (daddr_vld),
        .pc        (pc),
        .pc_vld    (pc_vld),
        .cyc_count (cyc_count),
        .hit       (hit_vec[gi]),
        .cyc_mode  (cmode_vec[gi]),
        .ev_q      (ev_arr[gi])
      );

      assign cfg_code[gi] = func_arr[gi][CODE_W-1:0];
      assign ev_watch[gi] = ev_arr[gi][0];
      assign ev_trig[gi]  = ev_arr[gi][1];
      assign ev_pcs[gi]   = ev_arr[gi][2];
      assign ev_das[gi]   = ev_arr[gi][3];
    end
  endgenerate

  assign cyc0_mode = cmode_vec[0];

  always_comb begin
    reg_rdata = '0;
    if (rd_ok) begin
      if (reg_addr == CNT_A) reg_rdata = cyc_count;
      for (int i = 0; i < NUM_CMP; i++) begin
        if (sel_comp[i]) reg_rdata = comp_arr[i];
        if (sel_mask[i]) reg_rdata = {{(DATA_W-MASK_W){1'b0}}, mask_arr[i]};
        if (sel_func[i]) reg_rdata = {{(DATA_W-FUNC_W){1'b0}}, func_arr[i]};
      end
    end
  end

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
  parameter int NUM_CMP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trace_en,
  input logic                    daddr_vld,
  input logic                    pc_vld,
  input logic                    cnt_ld,
  input logic                    cyc0_mode,
  input logic [31:0]             cyc_count,
  input logic [NUM_CMP-1:0][2:0] cfg_code,
  input logic [NUM_CMP-1:0]      hit_vec,
  input logic [NUM_CMP-1:0]      ev_watch,
  input logic [NUM_CMP-1:0]      ev_trig,
  input logic [NUM_CMP-1:0]      ev_pcs,
  input logic [NUM_CMP-1:0]      ev_das
);

  logic [NUM_CMP-1:0] any_ev;
  assign any_ev = ev_watch | ev_trig | ev_pcs | ev_das;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_chk
      // R4: one comparator drives at most one event lane
      a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_watch[gi], ev_trig[gi], ev_pcs[gi], ev_das[gi]}));

      // R4: an event follows a hit by one cycle, and only a hit
      a_r4_hit_to_event: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vec[gi] |=> any_ev[gi]);
      a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vec[gi] |=> !any_ev[gi]);

      // R7: an off code never produces an event
      a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_code[gi] == 3'd0 || cfg_code[gi] > 3'd4) |=> !any_ev[gi]);
    end
  endgenerate

  // R8: disabled unit is quiet and the counter holds
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> (any_ev == '0));
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> $stable(cyc_count));

  // R9: counter steps by one when enabled and not loaded
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !cnt_ld) |=> cyc_count == $past(cyc_count) + 32'd1);

  // R10: no valid stream and no cycle mode means no event
  a_r10_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!daddr_vld && !pc_vld && !cyc0_mode) |=> (any_ev == '0));

endmodule

bind addr_watch_bank wp_checker #(.NUM_CMP(NUM_CMP)) u_wp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .trace_en  (trace_en),
  .daddr_vld (daddr_vld),
  .pc_vld    (pc_vld),
  .cnt_ld    (cnt_ld),
  .cyc0_mode (cyc0_mode),
  .cyc_count (cyc_count),
  .cfg_code  (cfg_code),
  .hit_vec   (hit_vec),
  .ev_watch  (ev_watch),
  .ev_trig   (ev_trig),
  .ev_pcs    (ev_pcs),
  .ev_das    (ev_das)
);

// File: tb/addr_watch_bank_tb.sv
module addr_watch_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] daddr = '0;
  logic        daddr_vld = 1'b0;
  logic [31:0] pc = '0;
  logic        pc_vld = 1'b0;
  logic [3:0]  ev_watch, ev_trig, ev_pcs, ev_das;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int ev0_count = 0;
  string cur_req = "R1";
  logic [31:0] last_rd;

  // reference state
  logic [31:0] m_comp [4];
  logic [31:0] m_mask [4];
  logic [31:0] m_func [4];
  logic [31:0] m_cnt;

  always #5 clk = ~clk;

  addr_watch_bank u_dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .daddr(daddr), .daddr_vld(daddr_vld), .pc(pc), .pc_vld(pc_vld),
    .ev_watch(ev_watch), .ev_trig(ev_trig), .ev_pcs(ev_pcs), .ev_das(ev_das)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = 0;
    if (!trace_en) return 0;
    if (a == 8'h04) v = m_cnt;
    for (int i = 0; i < 4; i++) begin
      if (a == 8'(16 + 16*i)) v = m_comp[i];
      if (a == 8'(20 + 16*i)) v = m_mask[i];
      if (a == 8'(24 + 16*i)) v = m_func[i];
    end
    return v;
  endfunction

  // one clock: compare read data, predict events, advance model, compare events
  task automatic tick();
    logic [3:0] ew, et, ep, ed;
    logic [31:0] ncnt;
    #1;
    if (reg_rd) begin
      last_rd = reg_rdata;
      chk(reg_rdata === m_read(reg_addr), cur_req, "read data", reg_rdata, m_read(reg_addr));
    end
    ew = 0; et = 0; ep = 0; ed = 0;
    for (int i = 0; i < 4; i++) begin
      int code;
      logic [31:0] op;
      bit v, hit;
      code = int'(m_func[i] % 8);
      if (i == 0 && m_func[i][5]) begin op = m_cnt; v = 1; end
      else if ((code == 1 || code == 2) && m_func[i][4]) begin op = pc; v = pc_vld; end
      else begin op = daddr; v = daddr_vld; end
      hit = trace_en && v && (code >= 1 && code <= 4) &&
            ((op >> m_mask[i]) == (m_comp[i] >> m_mask[i]));
      if (hit) begin
        if (code == 1) ew[i] = 1;
        if (code == 2) et[i] = 1;
        if (code == 3) ep[i] = 1;
        if (code == 4) ed[i] = 1;
      end
    end
    ncnt = m_cnt;
    if (trace_en) begin
      ncnt = m_cnt + 1;
      if (reg_wr) begin
        if (reg_addr == 8'h04) ncnt = reg_wdata;
        for (int i = 0; i < 4; i++) begin
          if (reg_addr == 8'(16 + 16*i)) m_comp[i] = reg_wdata;
          if (reg_addr == 8'(20 + 16*i)) m_mask[i] = (reg_wdata > 15) ? 15 : reg_wdata;
          if (reg_addr == 8'(24 + 16*i)) m_func[i] = reg_wdata & ((i == 0) ? 32'h37 : 32'h17);
        end
      end
    end
    m_cnt = ncnt;
    @(posedge clk);
    @(negedge clk);
    if (ev_watch[0]) ev0_count++;
    chk({ev_watch, ev_trig, ev_pcs, ev_das} === {ew, et, ep, ed}, cur_req, "events",
        32'({ev_watch, ev_trig, ev_pcs, ev_das}), 32'({ew, et, ep, ed}));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    tick();
    reg_rd = 0;
    chk(last_rd === exp, req, "register value", last_rd, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_comp[i] = 0; m_mask[i] = 0; m_func[i] = 0; end
    m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state; R7: off comparators with matching address stay silent
    cur_req = "R1";
    daddr = 0; daddr_vld = 1;
    tick();
    chk({ev_watch, ev_trig, ev_pcs, ev_das} === 16'h0, "R1", "events after reset",
        32'({ev_watch, ev_trig, ev_pcs, ev_das}), 0);
    trace_en = 1;
    rd_expect(8'h04, 0, "R1");
    for (int i = 0; i < 4; i++) begin
      rd_expect(8'(16 + 16*i), 0, "R1");
      rd_expect(8'(24 + 16*i), 0, "R1");
    end
    cur_req = "R7";
    repeat (3) tick();
    chk(ev_watch === 0, "R7", "off comparator silent", 32'(ev_watch), 0);
    daddr_vld = 0;

    // R2: register map and read-back
    cur_req = "R2";
    for (int i = 0; i < 4; i++) begin
      wr(8'(16 + 16*i), 32'hA000_0000 + 32'(i * 'h111));
      wr(8'(20 + 16*i), 32'(i + 2));
    end
    for (int i = 0; i < 4; i++) begin
      rd_expect(8'(16 + 16*i), 32'hA000_0000 + 32'(i * 'h111), "R2");
      rd_expect(8'(20 + 16*i), 32'(i + 2), "R2");
    end
    wr(8'h0C, 32'hDEAD_BEEF);
    rd_expect(8'h0C, 0, "R2");
    rd_expect(8'h12, 0, "R2");

    // R3: mask clamp and low-bit ignore
    cur_req = "R3";
    wr(8'h44, 32'h25);
    rd_expect(8'h44, 15, "R3");
    wr(8'h40, 32'h1234_5670);
    wr(8'h44, 4);
    wr(8'h48, 1);
    daddr = 32'h1234_567F; daddr_vld = 1;
    tick();
    chk(ev_watch[3] === 1'b1, "R3", "masked hit", 32'(ev_watch[3]), 1);
    daddr = 32'h1234_5680;
    tick();
    chk(ev_watch[3] === 1'b0, "R3", "unmasked bit differs", 32'(ev_watch[3]), 0);
    daddr_vld = 0;

    // R4: each function code on comparator 3
    cur_req = "R4";
    wr(8'h44, 0);
    for (int c = 0; c < 8; c++) begin
      logic [3:0] exp;
      wr(8'h48, 32'(c));
      daddr = 32'h1234_5670; daddr_vld = 1;
      tick();
      daddr_vld = 0;
      exp = (c >= 1 && c <= 4) ? 4'(1 << (c - 1)) : 4'h0;
      chk({ev_das[3], ev_pcs[3], ev_trig[3], ev_watch[3]} === exp, "R4", "lane for code",
          32'({ev_das[3], ev_pcs[3], ev_trig[3], ev_watch[3]}), 32'(exp));
    end

    // R5: PC select
    cur_req = "R5";
    wr(8'h40, 32'h0000_ABC0);
    wr(8'h48, 32'h11);
    daddr = 0; daddr_vld = 1; pc = 32'h0000_ABC0; pc_vld = 1;
    tick();
    chk(ev_watch[3] === 1'b1, "R5", "pc compared for watch", 32'(ev_watch[3]), 1);
    wr(8'h48, 32'h13);
    tick();
    chk(ev_pcs[3] === 1'b0, "R5", "pc ignored for pc-sample", 32'(ev_pcs[3]), 0);
    daddr = 32'h0000_ABC0;
    tick();
    chk(ev_pcs[3] === 1'b1, "R5", "data addr for pc-sample", 32'(ev_pcs[3]), 1);
    daddr_vld = 0; pc_vld = 0;
    wr(8'h48, 0);

    // R6: cycle counter mode on comparator 0
    cur_req = "R6";
    wr(8'h10, 32'h0000_0108);
    wr(8'h14, 0);
    wr(8'h04, 32'h0000_0100);
    ev0_count = 0;
    wr(8'h18, 32'h21);
    repeat (20) tick();
    chk(ev0_count == 1, "R6", "cycle match count", 32'(ev0_count), 1);
    wr(8'h18, 0);
    wr(8'h28, 32'h21);
    rd_expect(8'h28, 32'h01, "R6");
    wr(8'h18, 32'hFFFF_FFFF);
    rd_expect(8'h18, 32'h37, "R6");
    wr(8'h18, 0);
    wr(8'h28, 0);

    // R8: disabled unit
    cur_req = "R8";
    wr(8'h20, 32'h4000);
    wr(8'h24, 0);
    wr(8'h28, 1);
    reg_rd = 1; reg_addr = 8'h04; tick(); reg_rd = 0;
    begin
      logic [31:0] c0;
      c0 = last_rd;
      trace_en = 0;
      daddr = 32'h4000; daddr_vld = 1;
      repeat (3) begin
        tick();
        chk(ev_watch[1] === 1'b0, "R8", "no event while disabled", 32'(ev_watch[1]), 0);
      end
      reg_rd = 1; reg_addr = 8'h20; tick(); reg_rd = 0;
      chk(last_rd === 0, "R8", "read while disabled", last_rd, 0);
      wr(8'h20, 32'h9999);
      daddr_vld = 0;
      trace_en = 1;
      rd_expect(8'h04, c0 + 1, "R8");
      rd_expect(8'h20, 32'h4000, "R8");
    end
    wr(8'h28, 0);

    // R9: counter load and wrap
    cur_req = "R9";
    wr(8'h04, 32'hFFFF_FFFE);
    rd_expect(8'h04, 32'hFFFF_FFFE, "R9");
    rd_expect(8'h04, 32'hFFFF_FFFF, "R9");
    rd_expect(8'h04, 32'h0000_0000, "R9");

    // R10: valid strobe qualification
    cur_req = "R10";
    wr(8'h30, 32'h500);
    wr(8'h34, 0);
    wr(8'h38, 4);
    daddr = 32'h500; daddr_vld = 0;
    tick();
    chk(ev_das[2] === 1'b0, "R10", "no event without valid", 32'(ev_das[2]), 0);
    daddr_vld = 1;
    tick();
    chk(ev_das[2] === 1'b1, "R10", "event with valid", 32'(ev_das[2]), 1);
    daddr_vld = 0;

    // R4: mixed traffic against the reference model every clock
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) begin
        int sel;
        sel = int'($urandom_range(0, 2));
        reg_wr = 1;
        reg_addr = 8'(16 + 16*k + 4*sel);
        reg_wdata = (sel == 0) ? $urandom : (sel == 1) ? 32'($urandom_range(0, 20)) :
                    32'($urandom_range(0, 63)) & 32'h1F;
      end
      daddr = m_comp[k] ^ 32'($urandom_range(0, 63));
      pc = m_comp[int'($urandom_range(0, 3))] ^ 32'($urandom_range(0, 7));
      daddr_vld = $urandom_range(0, 3) != 0;
      pc_vld = $urandom_range(0, 3) != 0;
      trace_en = $urandom_range(0, 15) != 0;
      tick();
      reg_wr = 0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule